// File: doc/BRIEF.md
# Two-Plane Cursor Overlay

This block lays a small bitmap cursor over a stream of 24-bit pixels. Each incoming pixel carries its own screen coordinates. When the pixel falls inside the square cursor window, the block reads one bit from each of two 1-bit-per-pixel bitmap planes in an internal byte RAM. The two bits form a 2-bit code. The selected cursor mode and that code decide what leaves the block. The pixel may keep its colour. It may take one of three programmable cursor colours. It may have all 24 bits inverted.

A host port fills the cursor RAM one byte at a time and loads the three colour registers. The cursor position, the size (32 or 64 pixels square), the mode, and the interlace controls are plain inputs that a register file outside the block holds.

The pixel path uses valid/ready. An accepted pixel appears at the output one clock later. The input is ready whenever the output register is empty or is being drained in the same cycle. While the output is stalled (`out_valid` high and `out_ready` low), the output pixel is held and no new pixel is taken. A pixel offered while `in_ready` is low stays offered and is not lost.

Top module: `cursor_overlay`

## Requirements
- R1: With mode 0 (`cur_mode` = 2'b00), every pixel leaves unchanged.
- R2: With mode 1, a code of 1, 2 or 3 outputs colour 1, 2 or 3 respectively. A code of 0 keeps the pixel. The code is plane-0 bit plus twice the plane-1 bit.
- R3: With mode 2, code 0 outputs colour 1 and code 1 outputs colour 2. Code 2 keeps the pixel. Code 3 outputs the bitwise inverse of all 24 bits of the incoming pixel.
- R4: With mode 3, code 2 outputs colour 1 and code 3 outputs colour 2. Codes 0 and 1 keep the pixel.
- R5: Each cursor row is S/8 bytes long, where S is 32 when `cur_big` is 0 and 64 when it is 1. Plane 0 starts at byte 0. Plane 1 starts at byte S*S/8. For cursor column c of row r, the bit comes from byte r*S/8 + c/8, at bit position 7 - (c mod 8), so the leftmost pixel is the MSB.
- R6: With `interlace` set, field line k of the cursor uses bitmap row 2k + `odd_field`. With `interlace` clear, it uses row k.
- R7: `cur_x` is a signed two's-complement value. A pixel is inside the cursor horizontally only when 0 <= `in_x` - `cur_x` < S. Pixels left of the start are never drawn, including when `cur_x` is negative.
- R8: A pixel whose bitmap row is outside 0..S-1 leaves unchanged. This includes lines above `cur_y`.
- R9: An accepted pixel appears on `out_pix` with `out_valid` set exactly one clock later. While `out_valid` is high and `out_ready` is low, `out_pix` and `out_valid` hold and `in_ready` is low.
- R10: A write with `col_we` high and `col_sel` equal to 1, 2 or 3 loads `col_data` into that colour register. `col_sel` equal to 0 changes nothing.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_we | input | 1 | Cursor RAM byte write strobe |
| ram_addr | input | 10 | Cursor RAM byte address |
| ram_wdata | input | 8 | Cursor RAM byte data |
| col_we | input | 1 | Colour register write strobe |
| col_sel | input | 2 | Colour register select (1..3) |
| col_data | input | 24 | Colour value |
| cur_mode | input | 2 | Cursor mode 0..3 |
| cur_big | input | 1 | 0: 32x32 cursor, 1: 64x64 cursor |
| cur_x | input | 13 | Signed cursor left column |
| cur_y | input | 12 | Cursor top line |
| interlace | input | 1 | Interlaced row stepping enable |
| odd_field | input | 1 | Current field parity |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high |
| in_pix | input | 24 | Input pixel colour |
| in_x | input | 12 | Input pixel column |
| in_y | input | 12 | Input pixel line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_pix | output | 24 | Output pixel colour |

## Verification
A wrong plane offset, a wrong row pitch or a reversed bit order shows up at once. The cursor shape at the output then differs from the bitmap written in, on the very next pixel inside the window. A bad window comparison leaks cursor colour outside the square, or drops it at the left or top edge, on the first pixel past the boundary. A decode error in any mode gives the wrong colour, or a missing inversion, one cycle after the offending pixel is accepted. The scans run every mode over full rows, so each code value is exercised. A broken stall path shows as a changed or duplicated output pixel in the first stalled cycle.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  typedef enum logic [1:0] {
    MODE_OFF       = 2'd0,
    MODE_TRICOLOR  = 2'd1,
    MODE_INVERTING = 2'd2,
    MODE_HIGHPLANE = 2'd3
  } cur_mode_e;

  typedef enum logic [2:0] {
    ACT_KEEP = 3'd0,
    ACT_COL1 = 3'd1,
    ACT_COL2 = 3'd2,
    ACT_COL3 = 3'd3,
    ACT_INV  = 3'd4
  } pix_act_e;

  function automatic pix_act_e decode_act(input cur_mode_e mode, input logic [1:0] code);
    pix_act_e a;
    a = ACT_KEEP;
    unique case (mode)
      MODE_OFF:       a = ACT_KEEP;
      MODE_TRICOLOR:
        unique case (code)
          2'd1: a = ACT_COL1;
          2'd2: a = ACT_COL2;
          2'd3: a = ACT_COL3;
          default: a = ACT_KEEP;
        endcase
      MODE_INVERTING:
        unique case (code)
          2'd0: a = ACT_COL1;
          2'd1: a = ACT_COL2;
          2'd3: a = ACT_INV;
          default: a = ACT_KEEP;
        endcase
      MODE_HIGHPLANE:
        unique case (code)
          2'd2: a = ACT_COL1;
          2'd3: a = ACT_COL2;
          default: a = ACT_KEEP;
        endcase
      default: a = ACT_KEEP;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/cursor_ram.sv
module cursor_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [7:0]    rdata0,
  output logic [7:0]    rdata1
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

endmodule

// File: rtl/cursor_locate.sv
module cursor_locate #(
  parameter int XW    = 12,
  parameter int MAXSZ = 64,
  localparam int LW   = $clog2(MAXSZ),
  localparam int AW   = $clog2(2 * MAXSZ * MAXSZ / 8),
  localparam int DW   = XW + 2
) (
  input  logic signed [XW:0] cur_x,
  input  logic [XW-1:0]      cur_y,
  input  logic               cur_big,
  input  logic               interlace,
  input  logic               odd_field,
  input  logic [XW-1:0]      in_x,
  input  logic [XW-1:0]      in_y,
  output logic               hit,
  output logic [AW-1:0]      addr0,
  output logic [AW-1:0]      addr1,
  output logic [2:0]         bitsel
);

  localparam int SMALL = MAXSZ / 2;

  logic signed [DW-1:0] dx;
  logic [XW:0]          dy;
  logic [XW+1:0]        row;
  logic [DW-1:0]        size_x;
  logic [XW+1:0]        size_y;
  logic                 hit_x, hit_y;
  logic [AW-1:0]        pitch, row_a, col_a, plane_off;

  always_comb begin
    dx     = $signed({2'b00, in_x}) - $signed({cur_x[XW], cur_x});
    dy     = {1'b0, in_y} - {1'b0, cur_y};
    row    = interlace ? {dy, odd_field} : {1'b0, dy};
    size_x = cur_big ? DW'(MAXSZ) : DW'(SMALL);
    size_y = cur_big ? (XW+2)'(MAXSZ) : (XW+2)'(SMALL);
    hit_x  = !dx[DW-1] && ($unsigned(dx) < size_x);
    hit_y  = !dy[XW] && (row < size_y);
    hit    = hit_x && hit_y;

    pitch     = cur_big ? AW'(MAXSZ / 8) : AW'(SMALL / 8);
    plane_off = cur_big ? AW'(MAXSZ * MAXSZ / 8) : AW'(SMALL * SMALL / 8);
    row_a     = AW'(row[LW-1:0]);
    col_a     = AW'(dx[LW-1:3]);
    addr0     = row_a * pitch + col_a;
    addr1     = addr0 + plane_off;
    bitsel    = ~dx[2:0];
  end

endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
  import cursor_pkg::*;
#(
  parameter int CW = 24
) (
  input  cur_mode_e      mode,
  input  logic           hit,
  input  logic [1:0]     code,
  input  logic [CW-1:0]  under,
  input  logic [CW-1:0]  col1,
  input  logic [CW-1:0]  col2,
  input  logic [CW-1:0]  col3,
  output logic [CW-1:0]  pix
);

  pix_act_e act;

  always_comb begin
    act = hit ? decode_act(mode, code) : ACT_KEEP;
    unique case (act)
      ACT_COL1: pix = col1;
      ACT_COL2: pix = col2;
      ACT_COL3: pix = col3;
      ACT_INV:  pix = ~under;
      default:  pix = under;
    endcase
  end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int XW    = 12,
  parameter int CW    = 24,
  parameter int MAXSZ = 64,
  localparam int DEPTH = 2 * MAXSZ * MAXSZ / 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ram_we,
  input  logic [AW-1:0]      ram_addr,
  input  logic [7:0]         ram_wdata,
  input  logic               col_we,
  input  logic [1:0]         col_sel,
  input  logic [CW-1:0]      col_data,
  input  logic [1:0]         cur_mode,
  input  logic               cur_big,
  input  logic signed [XW:0] cur_x,
  input  logic [XW-1:0]      cur_y,
  input  logic               interlace,
  input  logic               odd_field,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CW-1:0]      in_pix,
  input  logic [XW-1:0]      in_x,
  input  logic [XW-1:0]      in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CW-1:0]      out_pix
);

  logic [CW-1:0] colour [1:3];
  logic          hit;
  logic [AW-1:0] a0, a1;
  logic [2:0]    bsel;
  logic [7:0]    byte0, byte1;
  logic [1:0]    code;
  logic [CW-1:0] blended;
  logic          fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= 3; i++) colour[i] <= '0;
    end else if (col_we && col_sel != 2'd0) begin
      colour[col_sel] <= col_data;
    end
  end

  cursor_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
    .raddr0(a0), .raddr1(a1), .rdata0(byte0), .rdata1(byte1)
  );

  cursor_locate #(.XW(XW), .MAXSZ(MAXSZ)) u_loc (
    .cur_x(cur_x), .cur_y(cur_y), .cur_big(cur_big),
    .interlace(interlace), .odd_field(odd_field),
    .in_x(in_x), .in_y(in_y),
    .hit(hit), .addr0(a0), .addr1(a1), .bitsel(bsel)
  );

  assign code = {byte1[bsel], byte0[bsel]};

  cursor_blend #(.CW(CW)) u_blend (
    .mode(cur_mode_e'(cur_mode)), .hit(hit), .code(code), .under(in_pix),
    .col1(colour[1]), .col2(colour[2]), .col3(colour[3]), .pix(blended)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (fire) out_pix <= blended;
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_off_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cur_mode == 2'd0 |=> out_pix == $past(in_pix));

  assert_outside_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !hit |=> out_pix == $past(in_pix));

  assert_left_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $signed({2'b00, in_x}) >= $signed({cur_x[XW], cur_x}));

endmodule

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;

  logic clk = 0, rst_n = 0;
  logic ram_we = 0; logic [9:0] ram_addr = 0; logic [7:0] ram_wdata = 0;
  logic col_we = 0; logic [1:0] col_sel = 0; logic [23:0] col_data = 0;
  logic [1:0] cur_mode = 0; logic cur_big = 0;
  logic signed [12:0] cur_x = 0; logic [11:0] cur_y = 0;
  logic interlace = 0, odd_field = 0;
  logic in_valid = 0, in_ready; logic [23:0] in_pix = 0;
  logic [11:0] in_x = 0, in_y = 0;
  logic out_valid, out_ready = 1; logic [23:0] out_pix;

  int tests = 0, fails = 0;
  logic [7:0] shadow [1024];
  logic [23:0] c1, c2, c3;

  always #2.5 clk = ~clk;

  cursor_overlay u_cursor_overlay (.*);

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] model(int x, int y, logic [23:0] under);
    int sz, dy, row, col, pitch, a0, a1;
    logic [1:0] c;
    if (cur_mode == 0) return under;
    sz = cur_big ? 64 : 32;
    dy = y - int'(cur_y);
    if (dy < 0) return under;
    row = interlace ? 2 * dy + int'(odd_field) : dy;
    if (row >= sz) return under;
    col = x - int'(cur_x);
    if (col < 0 || col >= sz) return under;
    pitch = sz / 8;
    a0 = row * pitch + col / 8;
    a1 = a0 + pitch * sz;
    c = {shadow[a1][7 - col % 8], shadow[a0][7 - col % 8]};
    case (cur_mode)
      2'd1: case (c) 2'd1: return c1; 2'd2: return c2; 2'd3: return c3; default: return under; endcase
      2'd2: case (c) 2'd0: return c1; 2'd1: return c2; 2'd3: return ~under; default: return under; endcase
      default: case (c) 2'd2: return c1; 2'd3: return c2; default: return under; endcase
    endcase
  endfunction

  function automatic logic [23:0] under_of(int x, int y);
    return {8'(x) ^ 8'h5a, 8'(y), 8'hc3 ^ 8'(x + y)};
  endfunction

  task automatic push(input int x, input int y, output logic [23:0] got);
    @(negedge clk);
    in_x = 12'(x); in_y = 12'(y); in_pix = under_of(x, y); in_valid = 1;
    @(posedge clk);
    #1 in_valid = 0;
    @(negedge clk);
    got = out_pix;
  endtask

  task automatic set_colour(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    col_we = 1; col_sel = sel; col_data = d;
    @(negedge clk);
    col_we = 0;
  endtask

  task automatic scan(input string req, input int y, input int x0, input int x1);
    logic [23:0] g;
    for (int x = x0; x <= x1; x++) begin
      push(x, y, g);
      check(req, g, model(x, y, under_of(x, y)));
    end
  endtask

  task automatic t_reset();
    check("R11 out_valid", 24'(out_valid), 24'd0);
    check("R11 in_ready", 24'(in_ready), 24'd1);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      ram_we = 1; ram_addr = 10'(a); ram_wdata = 8'((a * 73 + 29) ^ (a >> 3));
      shadow[a] = ram_wdata;
    end
    @(negedge clk); ram_we = 0;
  endtask

  task automatic t_colours();
    c1 = 24'h112233; c2 = 24'h445566; c3 = 24'h778899;
    set_colour(2'd1, c1); set_colour(2'd2, c2); set_colour(2'd3, c3);
    set_colour(2'd0, 24'hffffff);
    cur_mode = 2'd1; cur_big = 1; cur_x = 100; cur_y = 50;
    scan("R10 colour registers and sel 0 ignored", 52, 100, 131);
  endtask

  task automatic t_mode_off();
    cur_mode = 2'd0; cur_big = 1; cur_x = 100; cur_y = 50;
    scan("R1 mode 0 passthrough", 55, 96, 170);
  endtask

  task automatic t_tricolor();
    cur_mode = 2'd1; cur_big = 1; cur_x = 100; cur_y = 50;
    scan("R2 mode 1 decode", 60, 98, 166);
    scan("R5 64-wide last row layout", 113, 100, 163);
  endtask

  task automatic t_inverting();
    cur_mode = 2'd2; cur_big = 1; cur_x = 10; cur_y = 5;
    scan("R3 mode 2 decode and invert", 7, 8, 76);
  endtask

  task automatic t_highplane();
    cur_mode = 2'd3; cur_big = 1; cur_x = 10; cur_y = 5;
    scan("R4 mode 3 decode", 30, 8, 76);
  endtask

  task automatic t_small();
    cur_mode = 2'd1; cur_big = 0; cur_x = 200; cur_y = 0;
    scan("R5 32-wide plane layout", 3, 198, 234);
    scan("R5 32-wide last row", 31, 198, 234);
  endtask

  task automatic t_interlace();
    cur_mode = 2'd1; cur_big = 1; cur_x = 40; cur_y = 20; interlace = 1;
    odd_field = 0; scan("R6 even field rows", 23, 40, 103);
    odd_field = 1; scan("R6 odd field rows", 23, 40, 103);
    scan("R6 beyond halved height", 52, 40, 50);
    interlace = 0; odd_field = 0;
  endtask

  task automatic t_windows();
    cur_mode = 2'd2; cur_big = 0; cur_x = -13'sd5; cur_y = 10;
    scan("R7 negative start column", 12, 0, 30);
    cur_x = 300;
    scan("R7 left of start", 12, 290, 299);
    scan("R8 above the cursor", 9, 300, 320);
    scan("R8 below the cursor", 42, 300, 320);
  endtask

  task automatic t_stall();
    logic [23:0] first, exp_b;
    cur_mode = 2'd1; cur_big = 1; cur_x = 100; cur_y = 50;
    @(negedge clk);
    out_ready = 0;
    in_x = 110; in_y = 60; in_pix = under_of(110, 60); in_valid = 1;
    @(posedge clk);
    #1 in_x = 111; in_pix = under_of(111, 60);
    @(negedge clk);
    first = out_pix;
    check("R9 one-cycle result", first, model(110, 60, under_of(110, 60)));
    check("R9 stalled in_ready low", 24'(in_ready), 24'd0);
    @(negedge clk);
    check("R9 held during stall", out_pix, first);
    check("R9 valid held", 24'(out_valid), 24'd1);
    out_ready = 1;
    @(posedge clk);
    #1 in_valid = 0;
    exp_b = model(111, 60, under_of(111, 60));
    @(negedge clk);
    check("R9 queued pixel after release", out_pix, exp_b);
    @(negedge clk);
    check("R9 output empties", 24'(out_valid), 24'd0);
  endtask

  initial begin
    #900000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_colours();
    t_mode_off();
    t_tricolor();
    t_inverting();
    t_highplane();
    t_small();
    t_interlace();
    t_windows();
    t_stall();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule